// File: doc/BRIEF.md
# Task-Switch Target Descriptor Checker

This block decides whether a protected-mode hardware task switch may go ahead. A switch request names the target state-segment selector, the reason for the switch, whether it was raised while an external event was being delivered, the selector currently held in the task register and the limit of the global descriptor table. The block first checks the target selector against the table. It then fetches the target descriptor through a request/valid handshake and checks the descriptor's type, present bit, expanded limit and busy flag. Finally it checks the current task register selector.

If every check passes, the block issues the busy-flag writes that the switch reason calls for. Each write goes out through a request/acknowledge handshake. For IRET and JMP the block first fetches the old descriptor, so that it can write that descriptor back with its busy flag cleared. When the writes are done it pulses commit together with a request to set the task-switched bit in the control register. If a check fails, the block pulses a fault strobe with an exception vector and an error code in selector format. A target that passes every check but is a 16-bit state segment raises an abort strobe instead of a commit.

The surrounding logic starts a switch with a one-cycle start pulse. It serves the descriptor reads and writes, and it acts on whichever strobe comes back.

Top module: `tsw_task_checker`

## Requirements
- R1: The only target types accepted in the 4-bit type field are 4'b1001 (32-bit available), 4'b1011 (32-bit busy), 4'b0001 (16-bit available) and 4'b0011 (16-bit busy). Any other type faults with vector 10 (invalid state segment).
- R2: A target whose present bit is 0 faults with vector 11 (segment not present).
- R3: The expanded limit must be at least 103 for a 32-bit type (type bit 3 = 1) and at least 43 for a 16-bit type. A smaller limit faults with vector 10.
- R4: Bit 1 of the type is the busy flag. Reasons are encoded CALL=0, JMP=1, IRET=2, gate=3. An IRET switch to a target that is not busy faults with vector 10. Any other reason with a busy target faults with vector 13 (general protection).
- R5: The target selector (bit 2 = table indicator, bits 15:3 = index) must have table indicator 0 and a non-zero index, and (selector OR 7) must not exceed the table limit. If not, the switch faults before any fetch: with vector 10 for IRET and with vector 13 for any other reason.
- R6: After the target descriptor passes, a task register selector with table indicator 1 or index 0 faults with vector 10. The error code is then built from the task register selector.
- R7: The error code is the faulting selector with bits 1:0 cleared and bit 0 then set to the external-event flag. Bits 15:2 are kept.
- R8: The checks are applied in this order: selector and table limit, type, present, limit, busy, task register. Only the first failing check is reported, and a fault is followed by no descriptor write.
- R9: On success, IRET and JMP write the old descriptor back with busy cleared (old type with bit 1 = 0). Every reason except IRET then writes the target with busy set (type OR 4'b0010). The old write comes first. Commit and set-task-switched pulse together after the last write is acknowledged.
- R10: A target of 16-bit type that passes every check raises the abort strobe, with no write and no commit.
- R11: After reset the block is idle with every strobe and request low. Start is ignored while a switch is in progress. Fault, commit and abort are one-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a switch check |
| reason_i | input | 2 | Switch reason: 0 CALL, 1 JMP, 2 IRET, 3 gate |
| ext_i | input | 1 | Switch raised during external event delivery |
| new_sel_i | input | SEL_W | Target state-segment selector |
| tr_sel_i | input | SEL_W | Current task register selector |
| tbl_limit_i | input | TBL_W | Global descriptor table limit |
| desc_req_o | output | 1 | Descriptor read request |
| desc_sel_o | output | SEL_W | Selector of the descriptor to read |
| desc_vld_i | input | 1 | Read data valid |
| desc_type_i | input | 4 | Type field of the read descriptor |
| desc_present_i | input | 1 | Present bit of the read descriptor |
| desc_limit_i | input | LIM_W | Expanded limit of the read descriptor |
| wr_req_o | output | 1 | Descriptor type write request |
| wr_sel_o | output | SEL_W | Selector of the descriptor to write |
| wr_type_o | output | 4 | New type field to write |
| wr_ack_i | input | 1 | Write accepted |
| fault_o | output | 1 | Fault strobe |
| fault_vec_o | output | 8 | Exception vector, valid with fault_o |
| fault_code_o | output | SEL_W | Error code, valid with fault_o |
| commit_o | output | 1 | Switch committed strobe |
| set_ts_o | output | 1 | Set the task-switched bit, pulses with commit_o |
| abort16_o | output | 1 | 16-bit target abort strobe |
| busy_o | output | 1 | Switch check in progress |

## Verification
The bench builds the block with its default parameters: 16-bit selectors and table limit, 32-bit descriptor limits and minimum limits of 103 and 43. With a 16-bit table limit the bench can place a target selector exactly at the table end and one step past it. With 32-bit limits it can place descriptor limits on both sides of each minimum. Some vectors fail two or three checks at once, to show which one takes precedence. Others cover every reason, so that the write sequence of each reason is compared with its own expected selectors and types.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic [1:0] {
        RSN_CALL = 2'd0,
        RSN_JMP  = 2'd1,
        RSN_IRET = 2'd2,
        RSN_GATE = 2'd3
    } tsw_reason_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_NEW,
        ST_FETCH_OLD,
        ST_WR_OLD,
        ST_WR_NEW
    } tsw_state_e;

    localparam logic [7:0] VEC_BAD_TSS = 8'd10;
    localparam logic [7:0] VEC_NOT_PRS = 8'd11;
    localparam logic [7:0] VEC_GEN_PRT = 8'd13;

    localparam logic [3:0] BUSY_MASK = 4'b0010;

endpackage

// File: rtl/tsw_sel_check.sv
module tsw_sel_check #(
    parameter int SEL_W = 16,
    parameter int TBL_W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [TBL_W-1:0] tbl_limit,
    output logic             sel_ok
);
    localparam int CMP_W = (TBL_W > SEL_W) ? TBL_W : SEL_W;

    logic [SEL_W-1:0] last_byte;
    logic [CMP_W-1:0] last_ext;
    logic [CMP_W-1:0] lim_ext;
    logic             in_global;
    logic             idx_nz;

    always_comb begin
        last_byte = sel | SEL_W'(7);
        last_ext  = CMP_W'(last_byte);
        lim_ext   = CMP_W'(tbl_limit);
        in_global = ~sel[2];
        idx_nz    = (sel >> 3) != '0;
        sel_ok    = in_global && idx_nz && (last_ext <= lim_ext);
    end

endmodule

// File: rtl/tsw_desc_check.sv
module tsw_desc_check
    import tsw_pkg::*;
#(
    parameter int LIM_W = 32,
    parameter int MIN32 = 103,
    parameter int MIN16 = 43
) (
    input  logic [3:0]       dtype,
    input  logic             present,
    input  logic [LIM_W-1:0] limit,
    input  logic             is_iret,
    output logic             ok,
    output logic [7:0]       vec,
    output logic             is16
);
    logic             type_ok;
    logic             busy;
    logic [LIM_W-1:0] min_lim;

    always_comb begin
        type_ok = ~dtype[2] & dtype[0];
        busy    = dtype[1];
        is16    = ~dtype[3];
        min_lim = dtype[3] ? LIM_W'(MIN32) : LIM_W'(MIN16);
        ok      = 1'b0;
        vec     = VEC_BAD_TSS;
        if (!type_ok) begin
            vec = VEC_BAD_TSS;
        end else if (!present) begin
            vec = VEC_NOT_PRS;
        end else if (limit < min_lim) begin
            vec = VEC_BAD_TSS;
        end else if (is_iret && !busy) begin
            vec = VEC_BAD_TSS;
        end else if (!is_iret && busy) begin
            vec = VEC_GEN_PRT;
        end else begin
            ok = 1'b1;
        end
    end

endmodule

// File: rtl/tsw_err_code.sv
module tsw_err_code #(
    parameter int SEL_W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             ext,
    output logic [SEL_W-1:0] code
);
    always_comb begin
        code = (sel & ~SEL_W'(3)) | SEL_W'(ext);
    end

endmodule

// File: rtl/tsw_task_checker.sv
module tsw_task_checker
    import tsw_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int TBL_W = 16,
    parameter int LIM_W = 32,
    parameter int MIN32 = 103,
    parameter int MIN16 = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       reason_i,
    input  logic             ext_i,
    input  logic [SEL_W-1:0] new_sel_i,
    input  logic [SEL_W-1:0] tr_sel_i,
    input  logic [TBL_W-1:0] tbl_limit_i,
    output logic             desc_req_o,
    output logic [SEL_W-1:0] desc_sel_o,
    input  logic             desc_vld_i,
    input  logic [3:0]       desc_type_i,
    input  logic             desc_present_i,
    input  logic [LIM_W-1:0] desc_limit_i,
    output logic             wr_req_o,
    output logic [SEL_W-1:0] wr_sel_o,
    output logic [3:0]       wr_type_o,
    input  logic             wr_ack_i,
    output logic             fault_o,
    output logic [7:0]       fault_vec_o,
    output logic [SEL_W-1:0] fault_code_o,
    output logic             commit_o,
    output logic             set_ts_o,
    output logic             abort16_o,
    output logic             busy_o
);
    typedef struct packed {
        tsw_state_e       st;
        logic [1:0]       rsn;
        logic             ext;
        logic [SEL_W-1:0] new_sel;
        logic [SEL_W-1:0] tr_sel;
        logic [3:0]       new_type;
        logic [3:0]       old_type;
        logic             fault;
        logic [7:0]       vec;
        logic [SEL_W-1:0] code;
        logic             commit;
        logic             abort;
    } regs_t;

    regs_t q, d;

    logic             sel_ok;
    logic             dsc_ok;
    logic [7:0]       dsc_vec;
    logic             dsc_is16;
    logic             tr_bad;
    logic [SEL_W-1:0] err_sel;
    logic             err_ext;
    logic [SEL_W-1:0] err_code;

    tsw_sel_check #(.SEL_W(SEL_W), .TBL_W(TBL_W)) i_sel_check (
        .sel       (new_sel_i),
        .tbl_limit (tbl_limit_i),
        .sel_ok    (sel_ok)
    );

    tsw_desc_check #(.LIM_W(LIM_W), .MIN32(MIN32), .MIN16(MIN16)) i_desc_check (
        .dtype   (desc_type_i),
        .present (desc_present_i),
        .limit   (desc_limit_i),
        .is_iret (q.rsn == RSN_IRET),
        .ok      (dsc_ok),
        .vec     (dsc_vec),
        .is16    (dsc_is16)
    );

    tsw_err_code #(.SEL_W(SEL_W)) i_err_code (
        .sel  (err_sel),
        .ext  (err_ext),
        .code (err_code)
    );

    always_comb begin
        tr_bad  = q.tr_sel[2] || ((q.tr_sel >> 3) == '0);
        err_sel = (q.st == ST_IDLE) ? new_sel_i : (dsc_ok ? q.tr_sel : q.new_sel);
        err_ext = (q.st == ST_IDLE) ? ext_i : q.ext;
    end

    always_comb begin
        d        = q;
        d.fault  = 1'b0;
        d.commit = 1'b0;
        d.abort  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.rsn     = reason_i;
                    d.ext     = ext_i;
                    d.new_sel = new_sel_i;
                    d.tr_sel  = tr_sel_i;
                    if (!sel_ok) begin
                        d.fault = 1'b1;
                        d.vec   = (reason_i == RSN_IRET) ? VEC_BAD_TSS : VEC_GEN_PRT;
                        d.code  = err_code;
                    end else begin
                        d.st = ST_FETCH_NEW;
                    end
                end
            end
            ST_FETCH_NEW: begin
                if (desc_vld_i) begin
                    d.new_type = desc_type_i;
                    if (!dsc_ok) begin
                        d.fault = 1'b1;
                        d.vec   = dsc_vec;
                        d.code  = err_code;
                        d.st    = ST_IDLE;
                    end else if (tr_bad) begin
                        d.fault = 1'b1;
                        d.vec   = VEC_BAD_TSS;
                        d.code  = err_code;
                        d.st    = ST_IDLE;
                    end else if (dsc_is16) begin
                        d.abort = 1'b1;
                        d.st    = ST_IDLE;
                    end else if (q.rsn == RSN_IRET || q.rsn == RSN_JMP) begin
                        d.st = ST_FETCH_OLD;
                    end else begin
                        d.st = ST_WR_NEW;
                    end
                end
            end
            ST_FETCH_OLD: begin
                if (desc_vld_i) begin
                    d.old_type = desc_type_i & ~BUSY_MASK;
                    d.st       = ST_WR_OLD;
                end
            end
            ST_WR_OLD: begin
                if (wr_ack_i) begin
                    if (q.rsn == RSN_IRET) begin
                        d.commit = 1'b1;
                        d.st     = ST_IDLE;
                    end else begin
                        d.st = ST_WR_NEW;
                    end
                end
            end
            ST_WR_NEW: begin
                if (wr_ack_i) begin
                    d.commit = 1'b1;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, vec: VEC_BAD_TSS, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        desc_req_o   = (q.st == ST_FETCH_NEW) || (q.st == ST_FETCH_OLD);
        desc_sel_o   = (q.st == ST_FETCH_OLD) ? q.tr_sel : q.new_sel;
        wr_req_o     = (q.st == ST_WR_OLD) || (q.st == ST_WR_NEW);
        wr_sel_o     = (q.st == ST_WR_OLD) ? q.tr_sel : q.new_sel;
        wr_type_o    = (q.st == ST_WR_OLD) ? q.old_type : (q.new_type | BUSY_MASK);
        fault_o      = q.fault;
        fault_vec_o  = q.vec;
        fault_code_o = q.code;
        commit_o     = q.commit;
        set_ts_o     = q.commit;
        abort16_o    = q.abort;
        busy_o       = (q.st != ST_IDLE);
    end

endmodule

// File: rtl/tsw_task_checker_sva.sv
module tsw_task_checker_sva #(
    parameter int SEL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             desc_req_o,
    input logic             wr_req_o,
    input logic [SEL_W-1:0] wr_sel_o,
    input logic [3:0]       wr_type_o,
    input logic             wr_ack_i,
    input logic             fault_o,
    input logic [7:0]       fault_vec_o,
    input logic [SEL_W-1:0] fault_code_o,
    input logic             commit_o,
    input logic             abort16_o,
    input logic             busy_o
);
    AST_FAULT_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (fault_vec_o == 8'd10 || fault_vec_o == 8'd11 || fault_vec_o == 8'd13)); // R1
    AST_CODE_BIT1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !fault_code_o[1]); // R7
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fault_o, commit_o, abort16_o}) <= 1); // R8
    AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !wr_req_o && !busy_o); // R8
    AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_sel_o) && $stable(wr_type_o)); // R9
    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        abort16_o |-> !wr_req_o && !busy_o); // R10
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_req_o && wr_req_o)); // R11
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o); // R11
endmodule

bind tsw_task_checker tsw_task_checker_sva #(.SEL_W(SEL_W)) i_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_req_o   (desc_req_o),
    .wr_req_o     (wr_req_o),
    .wr_sel_o     (wr_sel_o),
    .wr_type_o    (wr_type_o),
    .wr_ack_i     (wr_ack_i),
    .fault_o      (fault_o),
    .fault_vec_o  (fault_vec_o),
    .fault_code_o (fault_code_o),
    .commit_o     (commit_o),
    .abort16_o    (abort16_o),
    .busy_o       (busy_o)
);

// File: tb/test_tsw_task_checker.sv
`timescale 1ns/1ps
module test_tsw_task_checker;
    import tsw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  reason_i = '0;
    logic        ext_i = 1'b0;
    logic [15:0] new_sel_i = '0;
    logic [15:0] tr_sel_i = '0;
    logic [15:0] tbl_limit_i = '0;
    logic        desc_req_o;
    logic [15:0] desc_sel_o;
    logic        desc_vld_i = 1'b0;
    logic [3:0]  desc_type_i = '0;
    logic        desc_present_i = 1'b0;
    logic [31:0] desc_limit_i = '0;
    logic        wr_req_o;
    logic [15:0] wr_sel_o;
    logic [3:0]  wr_type_o;
    logic        wr_ack_i = 1'b0;
    logic        fault_o;
    logic [7:0]  fault_vec_o;
    logic [15:0] fault_code_o;
    logic        commit_o;
    logic        set_ts_o;
    logic        abort16_o;
    logic        busy_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tsw_task_checker i_tsw_task_checker (.*);

    typedef struct packed {
        logic [1:0]  rsn;
        logic        ext;
        logic [15:0] nsel;
        logic [15:0] tsel;
        logic [15:0] tlim;
        logic [3:0]  ntype;
        logic        pres;
        logic [31:0] nlim;
        logic [1:0]  kind;   // 0 commit, 1 fault, 2 abort
        logic [7:0]  vec;
        logic        from_tr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h9, 1'b1, 32'd103, 2'd0, 8'd0,  1'b0, 4'd9},  // R9 CALL
        '{2'd1, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h9, 1'b1, 32'd200, 2'd0, 8'd0,  1'b0, 4'd9},  // R9 JMP
        '{2'd2, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'hB, 1'b1, 32'd103, 2'd0, 8'd0,  1'b0, 4'd9},  // R9 IRET
        '{2'd3, 1'b1, 16'h0028, 16'h0020, 16'h00FF, 4'h9, 1'b1, 32'd103, 2'd0, 8'd0,  1'b0, 4'd9},  // R9 gate
        '{2'd0, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h2, 1'b1, 32'd103, 2'd1, 8'd10, 1'b0, 4'd1},  // R1
        '{2'd0, 1'b1, 16'h0028, 16'h0020, 16'h00FF, 4'h9, 1'b0, 32'd103, 2'd1, 8'd11, 1'b0, 4'd2},  // R2
        '{2'd0, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h9, 1'b1, 32'd102, 2'd1, 8'd10, 1'b0, 4'd3},  // R3
        '{2'd0, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h1, 1'b1, 32'd43,  2'd2, 8'd0,  1'b0, 4'd10}, // R10
        '{2'd0, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h1, 1'b1, 32'd42,  2'd1, 8'd10, 1'b0, 4'd3},  // R3
        '{2'd2, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h9, 1'b1, 32'd103, 2'd1, 8'd10, 1'b0, 4'd4},  // R4
        '{2'd0, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'hB, 1'b1, 32'd103, 2'd1, 8'd13, 1'b0, 4'd4},  // R4
        '{2'd0, 1'b1, 16'h0104, 16'h0020, 16'hFFFF, 4'h9, 1'b1, 32'd103, 2'd1, 8'd13, 1'b0, 4'd5},  // R5
        '{2'd2, 1'b0, 16'h0104, 16'h0020, 16'hFFFF, 4'hB, 1'b1, 32'd103, 2'd1, 8'd10, 1'b0, 4'd5},  // R5
        '{2'd1, 1'b0, 16'h0003, 16'h0020, 16'h00FF, 4'h9, 1'b1, 32'd103, 2'd1, 8'd13, 1'b0, 4'd5},  // R5
        '{2'd0, 1'b0, 16'h0100, 16'h0020, 16'h00FF, 4'h9, 1'b1, 32'd103, 2'd1, 8'd13, 1'b0, 4'd5},  // R5
        '{2'd2, 1'b1, 16'h0100, 16'h0020, 16'h00FF, 4'hB, 1'b1, 32'd103, 2'd1, 8'd10, 1'b0, 4'd5},  // R5
        '{2'd0, 1'b0, 16'h00F8, 16'h0020, 16'h00FF, 4'h9, 1'b1, 32'd103, 2'd0, 8'd0,  1'b0, 4'd5},  // R5
        '{2'd0, 1'b0, 16'h0028, 16'h0024, 16'h00FF, 4'h9, 1'b1, 32'd103, 2'd1, 8'd10, 1'b1, 4'd6},  // R6
        '{2'd3, 1'b1, 16'h0028, 16'h0000, 16'h00FF, 4'h9, 1'b1, 32'd103, 2'd1, 8'd10, 1'b1, 4'd6},  // R6
        '{2'd0, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h5, 1'b0, 32'd0,   2'd1, 8'd10, 1'b0, 4'd8},  // R8
        '{2'd0, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h9, 1'b0, 32'd0,   2'd1, 8'd11, 1'b0, 4'd8},  // R8
        '{2'd0, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'hB, 1'b1, 32'd50,  2'd1, 8'd10, 1'b0, 4'd8},  // R8
        '{2'd0, 1'b1, 16'h002B, 16'h0020, 16'h00FF, 4'h0, 1'b1, 32'd103, 2'd1, 8'd10, 1'b0, 4'd7},  // R7
        '{2'd2, 1'b0, 16'h0028, 16'h0020, 16'h00FF, 4'h3, 1'b1, 32'd43,  2'd2, 8'd0,  1'b0, 4'd10}, // R10
        '{2'd0, 1'b0, 16'h00F8, 16'h0020, 16'h00FE, 4'h9, 1'b1, 32'd103, 2'd1, 8'd13, 1'b0, 4'd5}   // R5
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int          nwr = 0;
        logic [15:0] w_sel [2];
        logic [3:0]  w_type [2];
        int          kind = -1;
        logic [7:0]  gvec = '0;
        logic [15:0] gcode = '0;
        logic        gts = 1'b0;
        logic [15:0] esel;
        logic [15:0] ecode;
        int          enwr;
        logic [15:0] ew_sel [2];
        logic [3:0]  ew_type [2];
        string       rq;
        rq = $sformatf("R%0d", v.req);
        w_sel[0] = '0; w_sel[1] = '0; w_type[0] = '0; w_type[1] = '0;
        @(negedge clk);
        reason_i = v.rsn; ext_i = v.ext; new_sel_i = v.nsel;
        tr_sel_i = v.tsel; tbl_limit_i = v.tlim; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 40 && kind < 0; c++) begin
            if (fault_o) begin
                kind = 1; gvec = fault_vec_o; gcode = fault_code_o;
            end else if (commit_o) begin
                kind = 0; gts = set_ts_o;
            end else if (abort16_o) begin
                kind = 2;
            end
            desc_vld_i = desc_req_o;
            if (desc_req_o && desc_sel_o == v.nsel) begin
                desc_type_i = v.ntype; desc_present_i = v.pres; desc_limit_i = v.nlim;
            end else begin
                desc_type_i = 4'hB; desc_present_i = 1'b1; desc_limit_i = 32'd103;
            end
            wr_ack_i = wr_req_o;
            if (wr_req_o) begin
                if (nwr < 2) begin
                    w_sel[nwr] = wr_sel_o; w_type[nwr] = wr_type_o;
                end
                nwr++;
            end
            if (kind < 0) @(negedge clk);
        end
        desc_vld_i = 1'b0; wr_ack_i = 1'b0;
        // expected values from the requirements
        esel  = v.from_tr ? v.tsel : v.nsel;
        ecode = {esel[15:2], 1'b0, v.ext};
        enwr = 0;
        if (v.kind == 2'd0) begin
            if (v.rsn == RSN_IRET || v.rsn == RSN_JMP) begin
                ew_sel[enwr] = v.tsel; ew_type[enwr] = 4'h9; enwr++;
            end
            if (v.rsn != RSN_IRET) begin
                ew_sel[enwr] = v.nsel; ew_type[enwr] = v.ntype | 4'b0010; enwr++;
            end
        end
        chk(kind == int'(v.kind), rq, "outcome", kind, v.kind);
        if (v.kind == 2'd1) begin
            chk(gvec == v.vec, rq, "vector", gvec, v.vec);
            chk(gcode == ecode, "R7", "error code", gcode, ecode);
        end
        if (v.kind == 2'd0) chk(gts == 1'b1, "R9", "set_ts with commit", gts, 1);
        chk(nwr == enwr, (v.kind == 2'd0) ? "R9" : "R8", "write count", nwr, enwr);
        for (int k = 0; k < enwr && k < nwr; k++) begin
            chk(w_sel[k] == ew_sel[k], "R9", "write selector", w_sel[k], ew_sel[k]);
            chk(w_type[k] == ew_type[k], "R9", "write type", w_type[k], ew_type[k]);
        end
        @(negedge clk);
        chk(!fault_o && !commit_o && !abort16_o, "R11", "strobe is one cycle",
            {fault_o, commit_o, abort16_o}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int          seen_busy;
        int          nwr;
        logic [15:0] wsel;
        logic [3:0]  wtype;
        logic        got_commit;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy_o && !fault_o && !commit_o && !abort16_o && !desc_req_o && !wr_req_o && !set_ts_o,
            "R11", "reset state",
            {busy_o, fault_o, commit_o, abort16_o, desc_req_o, wr_req_o, set_ts_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R11 start while busy is ignored
        @(negedge clk);
        reason_i = RSN_CALL; ext_i = 1'b0; new_sel_i = 16'h0028;
        tr_sel_i = 16'h0020; tbl_limit_i = 16'h00FF; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen_busy = busy_o ? 1 : 0;
        reason_i = RSN_JMP; new_sel_i = 16'h0030; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        nwr = 0; wsel = '0; wtype = '0; got_commit = 1'b0;
        for (int c = 0; c < 20 && !got_commit; c++) begin
            if (commit_o) got_commit = 1'b1;
            desc_vld_i = desc_req_o;
            desc_type_i = 4'h9; desc_present_i = 1'b1; desc_limit_i = 32'd103;
            wr_ack_i = wr_req_o;
            if (wr_req_o) begin
                wsel = wr_sel_o; wtype = wr_type_o; nwr++;
            end
            if (!got_commit) @(negedge clk);
        end
        desc_vld_i = 1'b0; wr_ack_i = 1'b0;
        chk(seen_busy == 1, "R11", "busy during switch", seen_busy, 1);
        chk(got_commit, "R11", "first switch commits", got_commit, 1);
        chk(nwr == 1, "R11", "write count of ignored restart", nwr, 1);
        chk(wsel == 16'h0028, "R11", "write selector from first start", wsel, 16'h0028);
        chk(wtype == 4'hB, "R11", "write type from first start", wtype, 4'hB);
        @(negedge clk);
        chk(!busy_o, "R11", "idle after commit", busy_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule